// File: doc/BRIEF.md
# Three-Rail Power Sequencer

This block is a clocked controller that turns a single, already-clean enable level into three active-high enable flags for downstream supply rails. When enable is asserted, the flags are released in a fixed 1-2-3 order. Each release waits for its own programmable delay, and that delay is counted from the moment the previous step finished. When enable is removed, the flags are pulled low in the reverse 3-2-1 order. Each fall has its own programmable delay, and these delays are separate from the power-up set.

A single down-counter is shared by all six delays, because only one of them runs at any time. The flags come straight from flip-flops, so they cannot glitch. Two status outputs are provided. `busy_o` shows that a delay is being counted. `done_o` shows that all rails are up and power-down has not begun.

Enable is treated in three cases:
- An enable that drops before the first flag is released cancels the sequence silently.
- An enable that drops part-way through power-up turns the sequence around, starting from the highest rail that is already on.
- An enable that returns during power-down has to wait until every rail is off.

Top module: `rail_seq_ctrl`

## Requirements
- R1: After reset, and for as long as `en_i` stays low in the idle state, `flag_o`, `busy_o` and `done_o` are all 0.
- R2: If `en_i` is sampled high at clock edge k while idle, `flag_o[0]` becomes 1 at edge k+U0+1, where U0 is `up_dly_i[0]`. A delay value of 0 therefore acts on the next edge.
- R3: `flag_o[i]` (i>0) rises Ui+1 edges after the edge on which `flag_o[i-1]` rose. A higher flag is never 1 while a lower one is 0.
- R4: If `en_i` is sampled low at edge k while all flags are up, `flag_o[2]` clears at edge k+D2+1, where Di is `dn_dly_i[i]`. `flag_o[1]` then clears D1+1 edges later, and `flag_o[0]` clears D0+1 edges after that.
- R5: The three power-up delays and the three power-down delays are independent. Each one affects only its own step.
- R6: If `en_i` is sampled low before `flag_o[0]` has risen, no flag ever toggles and the block is idle on the next edge (`busy_o` = 0).
- R7: If `en_i` is sampled low at edge k after some but not all flags have risen, power-up stops. The highest flag that is on, j, clears at edge k+Dj+1, and the lower flags follow as in R4.
- R8: Once power-down has begun, `en_i` is ignored until every flag is 0. A new power-up starts only from the idle state.
- R9: `busy_o` is 1 exactly while a power-up or power-down delay is being counted. It is never 1 together with `done_o`.
- R10: `done_o` is 1 exactly while all three flags are up and power-down has not begun.
- R11: At most one flag changes on any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Clean digital sequence enable |
| up_dly_i | input | NUM_RAILS x DLY_W | Power-up delays; index i belongs to flag i |
| dn_dly_i | input | NUM_RAILS x DLY_W | Power-down delays; index i belongs to flag i |
| flag_o | output | NUM_RAILS | Rail enable flags, bit 0 is the first rail |
| busy_o | output | 1 | A delay is being counted |
| done_o | output | 1 | All rails up, power-down not started |

## Verification
The bench builds the block with 4-bit delays and sweeps every power-up triple drawn from {0,1,3}. It pairs each triple with a rotated set of power-down delays, so a delay wired to the wrong step, or an off-by-one in one step, shows up as a wrong edge count on exactly one flag. Three directed patterns then separate the enable-handling cases: a cancel before the first release, which must leave every flag untouched, and a drop after one rail, which must turn around from that rail alone. The third is a re-assertion during power-down, which must let all rails reach zero before the first rail rises again.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_RISE = 2'd1,
      SEQ_HOLD = 2'd2,
      SEQ_FALL = 2'd3
   } seq_state_e;

endpackage

// File: rtl/rail_seq_timer.sv
module rail_seq_timer #(
   parameter int DLY_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DLY_W-1:0] load_val,
   input  logic             run,
   output logic             expired
);

   generate
      if (DLY_W < 1) begin : g_bad_width
         $error("rail_seq_timer: DLY_W must be at least 1");
      end
   endgenerate

   logic [DLY_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (run && (cnt_q != '0)) begin
         cnt_q <= cnt_q - DLY_W'(1);
      end
   end

   assign expired = run && (cnt_q == '0);

   // R2: a running, non-zero count steps down by exactly one per edge
   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - DLY_W'(1)));

   // R9: an idle counter holds its value
   assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/rail_seq_fsm.sv
module rail_seq_fsm
   import rail_seq_pkg::*;
#(
   parameter int NUM_RAILS = 3,
   parameter int DLY_W     = 16,
   localparam int IDX_W    = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            en_i,
   input  logic [NUM_RAILS-1:0][DLY_W-1:0] up_dly_i,
   input  logic [NUM_RAILS-1:0][DLY_W-1:0] dn_dly_i,
   input  logic                            expired,
   output logic                            load,
   output logic [DLY_W-1:0]                load_val,
   output logic                            set_en,
   output logic                            clr_en,
   output logic [IDX_W-1:0]                idx,
   output logic                            busy,
   output logic                            done
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_RAILS - 1);

   seq_state_e       state_q;
   logic [IDX_W-1:0] stage_q;
   logic [IDX_W-1:0] stage_inc;
   logic [IDX_W-1:0] stage_dec;

   assign stage_inc = stage_q + IDX_W'(1);
   assign stage_dec = stage_q - IDX_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         stage_q <= '0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (en_i) begin
                  state_q <= SEQ_RISE;
                  stage_q <= '0;
               end
            end
            SEQ_RISE: begin
               if (!en_i) begin
                  if (stage_q == '0) begin
                     state_q <= SEQ_IDLE;
                  end else begin
                     state_q <= SEQ_FALL;
                     stage_q <= stage_dec;
                  end
               end else if (expired) begin
                  if (stage_q == LAST) state_q <= SEQ_HOLD;
                  else                 stage_q <= stage_inc;
               end
            end
            SEQ_HOLD: begin
               if (!en_i) begin
                  state_q <= SEQ_FALL;
                  stage_q <= LAST;
               end
            end
            SEQ_FALL: begin
               if (expired) begin
                  if (stage_q == '0) state_q <= SEQ_IDLE;
                  else               stage_q <= stage_dec;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   always_comb begin
      load     = 1'b0;
      load_val = '0;
      unique case (state_q)
         SEQ_IDLE: begin
            if (en_i) begin
               load     = 1'b1;
               load_val = up_dly_i[0];
            end
         end
         SEQ_RISE: begin
            if (!en_i) begin
               if (stage_q != '0) begin
                  load     = 1'b1;
                  load_val = dn_dly_i[stage_dec];
               end
            end else if (expired && stage_q != LAST) begin
               load     = 1'b1;
               load_val = up_dly_i[stage_inc];
            end
         end
         SEQ_HOLD: begin
            if (!en_i) begin
               load     = 1'b1;
               load_val = dn_dly_i[LAST];
            end
         end
         SEQ_FALL: begin
            if (expired && stage_q != '0) begin
               load     = 1'b1;
               load_val = dn_dly_i[stage_dec];
            end
         end
         default: ;
      endcase
   end

   assign set_en = (state_q == SEQ_RISE) && en_i && expired;
   assign clr_en = (state_q == SEQ_FALL) && expired;
   assign idx    = stage_q;
   assign busy   = (state_q == SEQ_RISE) || (state_q == SEQ_FALL);
   assign done   = (state_q == SEQ_HOLD);

   // R8: a running power-down never returns to power-up
   assert_fall_commits_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_FALL) |=> (state_q == SEQ_FALL || state_q == SEQ_IDLE));

   // R6: cancel before the first release goes straight to idle
   assert_early_cancel_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_RISE && stage_q == '0 && !en_i) |=> (state_q == SEQ_IDLE));

   // R5: stage index stays inside the rail range
   assert_stage_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_q <= LAST));

endmodule

// File: rtl/rail_seq_flags.sv
module rail_seq_flags #(
   parameter int NUM_RAILS = 3,
   localparam int IDX_W    = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 set_en,
   input  logic                 clr_en,
   input  logic [IDX_W-1:0]     idx,
   output logic [NUM_RAILS-1:0] flag_q
);

   generate
      for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  flag_q[i] <= 1'b0;
            else if (set_en && idx == IDX_W'(i))         flag_q[i] <= 1'b1;
            else if (clr_en && idx == IDX_W'(i))         flag_q[i] <= 1'b0;
         end

         if (i > 0) begin : g_order
            // R3: a higher rail is only on when the one below it is on
            assert_rail_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
               flag_q[i] |-> flag_q[i-1]);
         end
      end
   endgenerate

   // R11: a single rail moves per edge
   assert_one_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(flag_q ^ $past(flag_q)) <= 1);

endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl #(
   parameter int NUM_RAILS = 3,
   parameter int DLY_W     = 16
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            en_i,
   input  logic [NUM_RAILS-1:0][DLY_W-1:0] up_dly_i,
   input  logic [NUM_RAILS-1:0][DLY_W-1:0] dn_dly_i,
   output logic [NUM_RAILS-1:0]            flag_o,
   output logic                            busy_o,
   output logic                            done_o
);

   localparam int IDX_W = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1;

   generate
      if (NUM_RAILS < 2) begin : g_bad_rails
         $error("rail_seq_ctrl: NUM_RAILS must be at least 2");
      end
      if (DLY_W < 1 || DLY_W > 32) begin : g_bad_dly
         $error("rail_seq_ctrl: DLY_W must lie in 1..32");
      end
   endgenerate

   logic             tmr_load;
   logic [DLY_W-1:0] tmr_val;
   logic             tmr_exp;
   logic             set_en;
   logic             clr_en;
   logic [IDX_W-1:0] idx;

   rail_seq_fsm #(.NUM_RAILS(NUM_RAILS), .DLY_W(DLY_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (en_i),
      .up_dly_i (up_dly_i),
      .dn_dly_i (dn_dly_i),
      .expired  (tmr_exp),
      .load     (tmr_load),
      .load_val (tmr_val),
      .set_en   (set_en),
      .clr_en   (clr_en),
      .idx      (idx),
      .busy     (busy_o),
      .done     (done_o)
   );

   rail_seq_timer #(.DLY_W(DLY_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .run      (busy_o),
      .expired  (tmr_exp)
   );

   rail_seq_flags #(.NUM_RAILS(NUM_RAILS)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (set_en),
      .clr_en (clr_en),
      .idx    (idx),
      .flag_q (flag_o)
   );

   // R10: done implies every rail is on
   assert_done_all_up_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (&flag_o));

   // R9: counting and done are exclusive
   assert_busy_not_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_o && done_o));

   // R6: cancel with no rail on leaves every rail off and the block idle
   assert_cancel_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && flag_o == '0 && !en_i) |=> (flag_o == '0 && !busy_o));

   // R1: idle with enable low keeps all rails off
   assert_idle_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !done_o && !en_i) |=> (flag_o == '0));

endmodule

// File: tb/sim_rail_seq_ctrl.sv
module sim_rail_seq_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NR = 3;
   localparam int DW = 4;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 en = 1'b0;
   logic [NR-1:0][DW-1:0] up_dly = '0;
   logic [NR-1:0][DW-1:0] dn_dly = '0;
   logic [NR-1:0]        flag;
   logic                 busy;
   logic                 done;

   int tests = 0;
   int fails = 0;
   int mon_fails = 0;
   bit finished = 1'b0;
   logic [NR-1:0] prev_flag = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rail_seq_ctrl #(.NUM_RAILS(NR), .DLY_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .en_i(en),
      .up_dly_i(up_dly), .dn_dly_i(dn_dly),
      .flag_o(flag), .busy_o(busy), .done_o(done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // R3 / R11 monitor at every falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         if ((flag[1] && !flag[0]) || (flag[2] && !flag[1])) begin
            mon_fails++;
            $display("FAIL R3: flags %b not ordered", flag);
         end
         if ($countones(flag ^ prev_flag) > 1) begin
            mon_fails++;
            $display("FAIL R11: flags moved %b -> %b", prev_flag, flag);
         end
      end
      prev_flag <= flag;
   end

   task automatic full_cycle(input int u0v, input int u1v, input int u2v,
                             input int d0v, input int d1v, input int d2v);
      int rise[3];
      int fall[3];
      int ex;
      for (int i = 0; i < 3; i++) begin rise[i] = -1; fall[i] = -1; end
      up_dly[0] = DW'(u0v); up_dly[1] = DW'(u1v); up_dly[2] = DW'(u2v);
      dn_dly[0] = DW'(d0v); dn_dly[1] = DW'(d1v); dn_dly[2] = DW'(d2v);
      en = 1'b1;
      for (int c = 1; c < 100; c++) begin
         @(negedge clk);
         if (c == 1) check(busy == 1'b1, "R9 busy during rise", int'(busy), 1);
         for (int i = 0; i < 3; i++) if (flag[i] && rise[i] < 0) rise[i] = c;
         if (rise[2] >= 0) break;
      end
      ex = 1 + u0v + 1;
      check(rise[0] == ex, "R2 flag0 rise", rise[0], ex);
      ex += u1v + 1;
      check(rise[1] == ex, "R3 flag1 rise", rise[1], ex);
      ex += u2v + 1;
      check(rise[2] == ex, "R3 R5 flag2 rise", rise[2], ex);
      check(done == 1'b1 && busy == 1'b0, "R10 done when all up", int'(done), 1);
      en = 1'b0;
      for (int c = 1; c < 100; c++) begin
         @(negedge clk);
         for (int i = 0; i < 3; i++) if (!flag[i] && fall[i] < 0) fall[i] = c;
         if (fall[0] >= 0) break;
      end
      ex = 1 + d2v + 1;
      check(fall[2] == ex, "R4 flag2 fall", fall[2], ex);
      ex += d1v + 1;
      check(fall[1] == ex, "R4 flag1 fall", fall[1], ex);
      ex += d0v + 1;
      check(fall[0] == ex, "R4 R5 flag0 fall", fall[0], ex);
      check(busy == 1'b0 && done == 1'b0, "R9 idle after fall", int'(busy), 0);
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int rise0;
      int fall0;
      bit seen_zero;
      bit bad;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R1 reset state
      check(flag == '0, "R1 flags after reset", int'(flag), 0);
      check(busy == 1'b0 && done == 1'b0, "R1 status after reset", int'({busy, done}), 0);

      // R2 R3 R4 R5 sweep
      for (int a = 0; a < 3; a++)
         for (int b = 0; b < 3; b++)
            for (int c = 0; c < 3; c++) begin
               int va = (a == 2) ? 3 : a;
               int vb = (b == 2) ? 3 : b;
               int vc = (c == 2) ? 3 : c;
               full_cycle(va, vb, vc, vc + 1, va + 2, vb);
            end

      // R6 cancel before first release
      up_dly = '{DW'(5), DW'(5), DW'(6)};
      dn_dly = '{DW'(1), DW'(1), DW'(1)};
      en = 1'b1;
      repeat (3) @(negedge clk);
      en = 1'b0;
      bad = 1'b0;
      for (int c = 0; c < 20; c++) begin
         @(negedge clk);
         if (flag != '0) bad = 1'b1;
      end
      check(!bad, "R6 no flag after cancel", int'(bad), 0);
      check(busy == 1'b0, "R6 idle after cancel", int'(busy), 0);

      // R7 drop after one rail: up (2,5,5), down (3,4,6)
      up_dly = '{DW'(5), DW'(5), DW'(2)};
      dn_dly = '{DW'(6), DW'(4), DW'(3)};
      en = 1'b1;
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         if (flag[0]) break;
      end
      en = 1'b0;
      fall0 = -1;
      bad = 1'b0;
      for (int c = 1; c < 30; c++) begin
         @(negedge clk);
         if (flag[1] || flag[2]) bad = 1'b1;
         if (!flag[0] && fall0 < 0) fall0 = c;
      end
      check(!bad, "R7 no higher rail after drop", int'(bad), 0);
      check(fall0 == 5, "R7 flag0 fall uses its own down delay", fall0, 5);

      // R8 re-enable during power-down: up (1,1,1), down (2,2,2)
      up_dly = '{DW'(1), DW'(1), DW'(1)};
      dn_dly = '{DW'(2), DW'(2), DW'(2)};
      en = 1'b1;
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         if (done) break;
      end
      en = 1'b0;
      @(negedge clk);
      en = 1'b1;
      seen_zero = 1'b0;
      bad = 1'b0;
      fall0 = -1;
      rise0 = -1;
      for (int c = 2; c < 40; c++) begin
         @(negedge clk);
         if (!seen_zero && flag == '0) begin seen_zero = 1'b1; fall0 = c; end
         else if (!seen_zero && $countones(flag) > $countones(prev_flag)) bad = 1'b1;
         if (seen_zero && flag[0] && rise0 < 0) rise0 = c;
      end
      check(!bad && seen_zero, "R8 no rise before all off", int'(bad), 0);
      check(fall0 == 10, "R8 all off time", fall0, 10);
      check(rise0 == 13, "R8 restart from idle", rise0, 13);
      check(done == 1'b1, "R10 done after restart", int'(done), 1);
      en = 1'b0;
      repeat (20) @(negedge clk);
      check(flag == '0 && busy == 1'b0, "R1 back to idle", int'(flag), 0);

      check(mon_fails == 0, "R3 R11 monitor", mon_fails, 0);
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule